// File: doc/BRIEF.md
# Branch-on-Immediate-Compare Unit

This unit resolves a pair of custom conditional branches that test a source register against a small signed constant carried in the instruction itself. The constant sits in the field a normal branch uses for its second register, so the compare needs only one register read. Each cycle the unit takes an instruction word, the program counter of that instruction and the value of its first source register. One clock later it reports three things: whether it recognises the instruction, whether the branch is taken, and the target address. It also reports the address the fetch stage should use next.

The decoder claims an instruction only when the major opcode is the conditional-branch opcode and the minor function code selects one of the two immediate-compare forms. The comparator checks all register bits against the sign-extended constant. The address path forms both the branch target and the sequential successor. In a cycle with no claimed instruction the address outputs keep their last values, so downstream logic sees no toggling from unrelated instructions.

Top module: `immbr_unit`

## Requirements
- R1: While `rst_n` is low, `claim_q`, `taken_q`, `target_q` and `next_pc_q` are all zero.
- R2: `claim_q` is 1 exactly when the instruction presented in the previous cycle has bits 6:0 = 1100011 and bits 14:12 equal to 010 or 011. Any other value of bits 14:12, or any other opcode, leaves `claim_q` at 0.
- R3: The compare constant is instruction bits 24:20 sign-extended to the full register width. A register value of all ones matches the constant 11111, and the value 0x0000001F does not.
- R4: With bits 14:12 = 010, `taken_q` is 1 exactly when the register value equals the compare constant.
- R5: With bits 14:12 = 011, `taken_q` is 1 exactly when the register value differs from the compare constant.
- R6: For a claimed instruction, `target_q` is the PC plus a byte offset. The offset is the 12-bit field {bit 31, bit 7, bits 30:25, bits 11:8}, sign-extended and shifted left by one. The sum wraps modulo 2^32.
- R7: For a claimed instruction, `next_pc_q` equals `target_q` when taken, and PC+4 (wrapping) when not taken.
- R8: In a cycle following an unclaimed instruction, `taken_q` is 0, and `target_q` and `next_pc_q` keep their previous values.
- R9: All outputs change only at the clock edge after the inputs are presented. Changing the inputs between edges does not move the outputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr | input | 32 | Instruction word under evaluation |
| pc | input | 32 | Address of that instruction |
| rs1_val | input | 32 | Value of the first source register |
| claim_q | output | 1 | Instruction recognised as an immediate-compare branch |
| taken_q | output | 1 | Branch condition holds |
| target_q | output | 32 | PC plus scaled signed offset |
| next_pc_q | output | 32 | Target when taken, PC+4 otherwise |

## Verification
The equal and not-equal forms are each run with a register value that matches the constant and one that does not, so that a swapped condition or an inverted comparator shows up. Register values near the sign boundary (all ones against -1, and 0x1F against -1) tell full sign extension apart from a 5-bit compare. The largest forward and backward offsets, plus a PC that wraps past zero, reveal a misplaced offset bit or a missing shift. Unclaimed function codes and a foreign opcode, presented after a taken branch, show that decode is strict and that the address outputs hold.

// File: rtl/immbr_pkg.sv
package immbr_pkg;

    // Instruction field geometry
    localparam int ILEN        = 32;
    localparam int OPC_W       = 7;
    localparam int F3_W        = 3;
    localparam int CMP_W       = 5;
    localparam int OFS_W       = 12;
    localparam int INSN_BYTES  = 4;

    // Field positions (decoded by this unit)
    localparam int F3_LSB      = 12;
    localparam int CMP_LSB     = 20;

    localparam logic [OPC_W-1:0] OPC_CBRANCH = 7'b1100011;
    localparam logic [F3_W-1:0]  F3_EQ_IMM   = 3'b010;
    localparam logic [F3_W-1:0]  F3_NE_IMM   = 3'b011;

    typedef enum logic {
        COND_EQ = 1'b0,
        COND_NE = 1'b1
    } cond_e;

endpackage

// File: rtl/immbr_decode.sv
module immbr_decode
    import immbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [ILEN-1:0] instr,
    output logic            claim,
    output cond_e           cond,
    output logic [XLEN-1:0] cmp_imm,
    output logic [XLEN-1:0] offset
);

    localparam int CMP_PAD = XLEN - CMP_W;
    localparam int OFS_PAD = XLEN - OFS_W - 1;

    logic [OPC_W-1:0] opc;
    logic [F3_W-1:0]  f3;
    logic [CMP_W-1:0] cmp_raw;
    logic [OFS_W-1:0] ofs_raw;

    always_comb begin
        opc     = instr[OPC_W-1:0];
        f3      = instr[F3_LSB +: F3_W];
        cmp_raw = instr[CMP_LSB +: CMP_W];
        // scattered offset: sign, then bit 7, then upper run, then lower run
        ofs_raw = {instr[31], instr[7], instr[30:25], instr[11:8]};

        claim = (opc == OPC_CBRANCH) && ((f3 == F3_EQ_IMM) || (f3 == F3_NE_IMM));
        cond  = (f3 == F3_NE_IMM) ? COND_NE : COND_EQ;

        cmp_imm = {{CMP_PAD{cmp_raw[CMP_W-1]}}, cmp_raw};
        offset  = {{OFS_PAD{ofs_raw[OFS_W-1]}}, ofs_raw, 1'b0};
    end

endmodule

// File: rtl/immbr_cmp.sv
module immbr_cmp
    import immbr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CHUNK = 8
) (
    input  logic [XLEN-1:0] rs1_val,
    input  logic [XLEN-1:0] cmp_imm,
    input  cond_e           cond,
    output logic            hit
);

    localparam int NCHUNK = (XLEN + CHUNK - 1) / CHUNK;
    localparam int PADW   = NCHUNK * CHUNK;

    logic [PADW-1:0]   a_pad;
    logic [PADW-1:0]   b_pad;
    logic [NCHUNK-1:0] chunk_eq;
    logic              all_eq;

    always_comb begin
        a_pad = '0;
        b_pad = '0;
        a_pad[XLEN-1:0] = rs1_val;
        b_pad[XLEN-1:0] = cmp_imm;
    end

    // equality split into independent slices, then reduced
    for (genvar g = 0; g < NCHUNK; g++) begin : g_slice
        assign chunk_eq[g] = (a_pad[g*CHUNK +: CHUNK] == b_pad[g*CHUNK +: CHUNK]);
    end

    always_comb begin
        all_eq = &chunk_eq;
        hit    = (cond == COND_NE) ? ~all_eq : all_eq;
    end

endmodule

// File: rtl/immbr_addr.sv
module immbr_addr
    import immbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] offset,
    output logic [XLEN-1:0] target,
    output logic [XLEN-1:0] seq_pc
);

    localparam logic [XLEN-1:0] STEP = XLEN'(INSN_BYTES);

    always_comb begin
        target = pc + offset;
        seq_pc = pc + STEP;
    end

endmodule

// File: rtl/immbr_unit.sv
module immbr_unit
    import immbr_pkg::*;
#(
    parameter int XLEN  = 32,
    parameter int CHUNK = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ILEN-1:0] instr,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs1_val,
    output logic            claim_q,
    output logic            taken_q,
    output logic [XLEN-1:0] target_q,
    output logic [XLEN-1:0] next_pc_q
);

    typedef struct packed {
        logic            claim;
        logic            taken;
        logic [XLEN-1:0] target;
        logic [XLEN-1:0] next_pc;
    } res_t;

    logic            dec_claim;
    cond_e           dec_cond;
    logic [XLEN-1:0] dec_cmp_imm;
    logic [XLEN-1:0] dec_offset;
    logic            cmp_hit;
    logic [XLEN-1:0] br_target;
    logic [XLEN-1:0] br_seq;

    res_t res_d;
    res_t res_q;

    immbr_decode #(.XLEN(XLEN)) u_decode (
        .instr   (instr),
        .claim   (dec_claim),
        .cond    (dec_cond),
        .cmp_imm (dec_cmp_imm),
        .offset  (dec_offset)
    );

    immbr_cmp #(.XLEN(XLEN), .CHUNK(CHUNK)) u_cmp (
        .rs1_val (rs1_val),
        .cmp_imm (dec_cmp_imm),
        .cond    (dec_cond),
        .hit     (cmp_hit)
    );

    immbr_addr #(.XLEN(XLEN)) u_addr (
        .pc     (pc),
        .offset (dec_offset),
        .target (br_target),
        .seq_pc (br_seq)
    );

    always_comb begin
        res_d = res_q;
        res_d.claim = dec_claim;
        res_d.taken = 1'b0;
        if (dec_claim) begin
            res_d.taken   = cmp_hit;
            res_d.target  = br_target;
            res_d.next_pc = cmp_hit ? br_target : br_seq;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else begin
            res_q <= res_d;
        end
    end

    assign claim_q   = res_q.claim;
    assign taken_q   = res_q.taken;
    assign target_q  = res_q.target;
    assign next_pc_q = res_q.next_pc;

endmodule

// File: rtl/immbr_unit_chk.sv
module immbr_unit_chk
    import immbr_pkg::*;
#(
    parameter int XLEN = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic [ILEN-1:0] instr,
    input logic [XLEN-1:0] pc,
    input logic [XLEN-1:0] rs1_val,
    input logic            claim_q,
    input logic            taken_q,
    input logic [XLEN-1:0] target_q,
    input logic [XLEN-1:0] next_pc_q
);

    logic armed_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    function automatic logic [XLEN-1:0] sx5(input logic [CMP_W-1:0] v);
        return {{(XLEN-CMP_W){v[CMP_W-1]}}, v};
    endfunction

    // R1: reset clears outputs
    always_comb begin
        if (!rst_n) begin
            p_reset_clear_r1: assert (!claim_q && !taken_q && target_q == '0 && next_pc_q == '0);
        end
    end

    // R2: claim follows the previous instruction's opcode and function code
    p_claim_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q |-> claim_q == ($past(instr[6:0]) == OPC_CBRANCH &&
                                ($past(instr[14:12]) == F3_EQ_IMM || $past(instr[14:12]) == F3_NE_IMM)));

    // R4: equal form
    p_eq_form_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && claim_q && $past(instr[14:12]) == F3_EQ_IMM)
            |-> taken_q == ($past(rs1_val) == sx5($past(instr[24:20]))));

    // R5: not-equal form
    p_ne_form_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && claim_q && $past(instr[14:12]) == F3_NE_IMM)
            |-> taken_q == ($past(rs1_val) != sx5($past(instr[24:20]))));

    // R7: redirect when taken
    p_next_taken_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (claim_q && taken_q) |-> next_pc_q == target_q);

    // R7: fall through when not taken
    p_next_seq_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && claim_q && !taken_q) |-> next_pc_q == $past(pc) + XLEN'(INSN_BYTES));

    // R8: no taken flag without a claim
    p_taken_needs_claim_r8: assert property (@(posedge clk) disable iff (!rst_n)
        taken_q |-> claim_q);

    // R8: address outputs hold across unclaimed cycles
    p_hold_addr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && !claim_q) |-> ($stable(target_q) && $stable(next_pc_q)));

endmodule

bind immbr_unit immbr_unit_chk #(.XLEN(XLEN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .instr     (instr),
    .pc        (pc),
    .rs1_val   (rs1_val),
    .claim_q   (claim_q),
    .taken_q   (taken_q),
    .target_q  (target_q),
    .next_pc_q (next_pc_q)
);

// File: tb/tb_immbr_unit.sv
`timescale 1ns/1ps
module tb_immbr_unit;

    logic        clk;
    logic        rst_n;
    logic [31:0] instr;
    logic [31:0] pc;
    logic [31:0] rs1_val;
    logic        claim_q;
    logic        taken_q;
    logic [31:0] target_q;
    logic [31:0] next_pc_q;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 0;

    immbr_unit dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .instr     (instr),
        .pc        (pc),
        .rs1_val   (rs1_val),
        .claim_q   (claim_q),
        .taken_q   (taken_q),
        .target_q  (target_q),
        .next_pc_q (next_pc_q)
    );

    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual=0x%08h expected=0x%08h", req, what, act, exp);
        end
    endtask

    // build an immediate-compare branch; off is a byte offset (even)
    function automatic logic [31:0] enc(input logic [2:0] f3, input logic [4:0] c5,
                                        input logic [4:0] rsi, input int off);
        logic [12:0] o;
        logic [11:0] k;
        o = off[12:0];
        k = o[12:1];
        return {k[11], k[9:4], c5, rsi, f3, k[3:0], k[10], 7'b1100011};
    endfunction

    task automatic drive(input logic [31:0] i, input logic [31:0] p, input logic [31:0] r);
        @(negedge clk);
        instr = i; pc = p; rs1_val = r;
        @(posedge clk);
        #1;
    endtask

    task automatic expect_branch(input string req, input bit exp_taken,
                                 input logic [31:0] p, input int off);
        logic [31:0] t;
        t = p + 32'(off);
        check(req, "claim", {31'd0, claim_q}, 32'd1);
        check(req, "taken", {31'd0, taken_q}, {31'd0, exp_taken});
        check("R6", "target", target_q, t);
        check("R7", "next_pc", next_pc_q, exp_taken ? t : p + 32'd4);
    endtask

    task automatic t_reset;
        check("R1", "claim", {31'd0, claim_q}, 32'd0);
        check("R1", "taken", {31'd0, taken_q}, 32'd0);
        check("R1", "target", target_q, 32'd0);
        check("R1", "next_pc", next_pc_q, 32'd0);
    endtask

    task automatic t_eq_form;
        drive(enc(3'b010, 5'd7, 5'd3, 64), 32'h0000_1000, 32'd7);
        expect_branch("R4", 1'b1, 32'h0000_1000, 64);
        drive(enc(3'b010, 5'd7, 5'd3, 64), 32'h0000_1000, 32'd8);
        expect_branch("R4", 1'b0, 32'h0000_1000, 64);
    endtask

    task automatic t_ne_form;
        drive(enc(3'b011, 5'd2, 5'd9, -32), 32'h0000_2000, 32'd5);
        expect_branch("R5", 1'b1, 32'h0000_2000, -32);
        drive(enc(3'b011, 5'd2, 5'd9, -32), 32'h0000_2000, 32'd2);
        expect_branch("R5", 1'b0, 32'h0000_2000, -32);
    endtask

    task automatic t_sign_ext;
        // R3: constant 11111 is -1 across all 32 bits
        drive(enc(3'b010, 5'b11111, 5'd1, 8), 32'h0000_0100, 32'hFFFF_FFFF);
        expect_branch("R3", 1'b1, 32'h0000_0100, 8);
        drive(enc(3'b010, 5'b11111, 5'd1, 8), 32'h0000_0100, 32'h0000_001F);
        expect_branch("R3", 1'b0, 32'h0000_0100, 8);
        drive(enc(3'b011, 5'b10000, 5'd1, 8), 32'h0000_0100, 32'hFFFF_FFF0);
        expect_branch("R3", 1'b0, 32'h0000_0100, 8);
    endtask

    task automatic t_offsets;
        drive(enc(3'b010, 5'd0, 5'd4, 4094), 32'h0001_0000, 32'd0);
        expect_branch("R6", 1'b1, 32'h0001_0000, 4094);
        drive(enc(3'b010, 5'd0, 5'd4, -4096), 32'h0001_0000, 32'd0);
        expect_branch("R6", 1'b1, 32'h0001_0000, -4096);
        drive(enc(3'b010, 5'd0, 5'd4, 1366), 32'h0001_0000, 32'd0);
        expect_branch("R6", 1'b1, 32'h0001_0000, 1366);
        drive(enc(3'b010, 5'd0, 5'd4, 16), 32'hFFFF_FFF8, 32'd0);
        expect_branch("R6", 1'b1, 32'hFFFF_FFF8, 16);
        // R7: fall-through wraps as well
        drive(enc(3'b010, 5'd0, 5'd4, 16), 32'hFFFF_FFFC, 32'd1);
        expect_branch("R7", 1'b0, 32'hFFFF_FFFC, 16);
    endtask

    task automatic t_unclaimed;
        logic [31:0] t;
        drive(enc(3'b010, 5'd1, 5'd2, 200), 32'h0000_3000, 32'd1);
        t = 32'h0000_3000 + 32'd200;
        check("R8", "setup target", target_q, t);
        for (int f = 0; f < 8; f++) begin
            if (f == 2 || f == 3) continue;
            drive(enc(3'(f), 5'd1, 5'd2, 40), 32'h0000_4000, 32'd1);
            check("R2", "claim unclaimed f3", {31'd0, claim_q}, 32'd0);
            check("R8", "taken unclaimed", {31'd0, taken_q}, 32'd0);
            check("R8", "target held", target_q, t);
            check("R8", "next_pc held", next_pc_q, t);
        end
        // foreign opcode with an eq-form function code
        drive({enc(3'b010, 5'd1, 5'd2, 40)} ^ 32'h0000_0050, 32'h0000_5000, 32'd1);
        check("R2", "claim foreign opcode", {31'd0, claim_q}, 32'd0);
        check("R8", "target held foreign", target_q, t);
    endtask

    task automatic t_latency;
        drive(enc(3'b011, 5'd3, 5'd6, 100), 32'h0000_6000, 32'd3);
        expect_branch("R9", 1'b0, 32'h0000_6000, 100);
        @(negedge clk);
        instr = enc(3'b011, 5'd3, 5'd6, 12); pc = 32'h0000_7000; rs1_val = 32'd4;
        #1;
        check("R9", "taken before edge", {31'd0, taken_q}, 32'd0);
        check("R9", "next_pc before edge", next_pc_q, 32'h0000_6004);
        @(posedge clk);
        #1;
        expect_branch("R9", 1'b1, 32'h0000_7000, 12);
    endtask

    initial begin
        rst_n = 1'b0; instr = '0; pc = '0; rs1_val = '0;
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_eq_form();
        t_ne_form();
        t_sign_ext();
        t_offsets();
        t_unclaimed();
        t_latency();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

endmodule